// File: doc/BRIEF.md
# Gate Driver Slew-Phase Timer

This block times the slew-limited interval of a high-side and a low-side gate driver. Each side follows its own PWM command. Every change of a command starts a controlled-current phase on that side. The phase lasts for a time chosen by a 3-bit code, and the block then switches the side to full drive strength. While the phase runs, the side presents a 3-bit current-level code. A rising command selects the side's source code and a falling command selects its sink code. The code is passed through unchanged, and an analog stage turns it into a current.

The phase time comes from a fixed, non-linear table. The table is converted to clock cycles from a clock-frequency parameter, and each value is rounded up. A shared driver enable forces both gates low and stops every phase. Each side keeps its own time code and its own pair of current codes, so the two sides run independently.

Top module: `gdrv_slew_timer`

## Requirements
- R1: After reset, every gate, phase flag, full-strength flag and current code output is 0.
- R2: With the enable high, a change of a side's command makes that side's gate equal the new command level one cycle later, and its phase flag rises in that same cycle.
- R3: A phase lasts N cycles, where N = ceil(t × CLK_MHZ / 1000) and t in ns is looked up from the 3-bit time code: 0→4700, 1→2500, 2→1800, 3→1300, 4→1100, 5→900, 6→750, 7→550. At 125 MHz this gives 588, 313, 225, 163, 138, 113, 94 and 69.
- R4: During a phase the current code equals the side's source code if the command rose, or its sink code if the command fell. The code is passed through unchanged (0=250 mA … 7=1000 mA).
- R5: When a phase ends without a new command change, the full-strength flag rises in the next cycle and stays high until the next command change. The current code reads 0 outside a phase. The phase flag and the full-strength flag are never high together.
- R6: A command change during an active phase restarts the phase. The new phase takes its length from the current time code and its current code from the new direction.
- R7: While the enable is low, both gates, both phase flags, both full-strength flags and both codes are 0 from the next cycle on, and command changes start nothing. When the enable returns, a side whose command is high sees this as a rising change and starts a phase.
- R8: The time code and the current codes are sampled only at the command change. Changing them during a phase does not alter that phase's length or code.
- R9: The two sides are independent. A phase on one side leaves the gate, flags and code of the other side unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| drvEn | input | 1 | Driver enable for both sides |
| pwmHi | input | 1 | High-side PWM command |
| pwmLo | input | 1 | Low-side PWM command |
| tonHi | input | 3 | High-side phase time code |
| tonLo | input | 3 | Low-side phase time code |
| srcHi | input | 3 | High-side source current code |
| snkHi | input | 3 | High-side sink current code |
| srcLo | input | 3 | Low-side source current code |
| snkLo | input | 3 | Low-side sink current code |
| gateHi | output | 1 | High-side gate level |
| gateLo | output | 1 | Low-side gate level |
| slewHi | output | 1 | High-side controlled-current phase active |
| slewLo | output | 1 | Low-side controlled-current phase active |
| fullHi | output | 1 | High-side full-strength drive |
| fullLo | output | 1 | Low-side full-strength drive |
| codeHi | output | 3 | High-side current code during the phase |
| codeLo | output | 3 | Low-side current code during the phase |

## Verification
A command change driven in cycle k appears on the gate, the phase flag and the code in cycle k+1. The phase flag is last high in cycle k+N, and the full-strength flag and the zero code show in cycle k+N+1. The effect of dropping the enable is due one cycle after it is sampled. Every expectation is queued with the absolute cycle it belongs to, worked out from these offsets and the rounded-up table. Outputs are compared on the falling clock edge of exactly that cycle, so no result is read early or late.

// File: rtl/gdrv_slew_pkg.sv
package gdrv_slew_pkg;

  localparam int SIDES   = 2;
  localparam int SIDE_HI = 0;
  localparam int SIDE_LO = 1;
  localparam int CODE_W  = 3;

  // strobes from control to datapath, one set per side
  typedef struct packed {
    logic launch;   // accepted command change this cycle
    logic rise;     // direction of that change
    logic expire;   // last cycle of a phase, no new change
    logic off;      // driver enable low
  } phase_strobe_t;

  // phase time in ns for each 3-bit time code
  function automatic int tonNs(input logic [2:0] sel);
    case (sel)
      3'd0:    return 4700;
      3'd1:    return 2500;
      3'd2:    return 1800;
      3'd3:    return 1300;
      3'd4:    return 1100;
      3'd5:    return 900;
      3'd6:    return 750;
      default: return 550;
    endcase
  endfunction

  // ns to cycles, rounded up
  function automatic int nsToCycles(input int ns, input int clkMhz);
    return (ns * clkMhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/gdrv_slew_ctrl.sv
module gdrv_slew_ctrl
  import gdrv_slew_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            drvEn,
  input  logic [SIDES-1:0]                pwm,
  input  logic [SIDES-1:0][CNT_W-1:0]     phaseLen,
  output phase_strobe_t [SIDES-1:0]       strobe,
  output logic [SIDES-1:0]                slew
);

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic             pwmQ;
    logic             slewQ;
    logic [CNT_W-1:0] cnt;
    logic             launch;
    logic             lastCyc;

    assign launch  = drvEn && (pwm[s] != pwmQ);
    assign lastCyc = slewQ && (cnt == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pwmQ  <= 1'b0;
        slewQ <= 1'b0;
        cnt   <= '0;
      end else if (!drvEn) begin
        pwmQ  <= 1'b0;
        slewQ <= 1'b0;
        cnt   <= '0;
      end else if (launch) begin
        pwmQ  <= pwm[s];
        slewQ <= 1'b1;
        cnt   <= phaseLen[s] - CNT_W'(1);
      end else if (slewQ) begin
        if (lastCyc) slewQ <= 1'b0;
        else         cnt   <= cnt - CNT_W'(1);
      end
    end

    assign slew[s]          = slewQ;
    assign strobe[s].launch = launch;
    assign strobe[s].rise   = pwm[s];
    assign strobe[s].expire = drvEn && lastCyc && !launch;
    assign strobe[s].off    = !drvEn;
  end

endmodule

// File: rtl/gdrv_slew_dp.sv
module gdrv_slew_dp
  import gdrv_slew_pkg::*;
#(
  parameter int CLK_MHZ = 125,
  parameter int CNT_W   = 10
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  phase_strobe_t [SIDES-1:0]         strobe,
  input  logic [SIDES-1:0][2:0]             tonSel,
  input  logic [SIDES-1:0][CODE_W-1:0]      srcSel,
  input  logic [SIDES-1:0][CODE_W-1:0]      snkSel,
  output logic [SIDES-1:0][CNT_W-1:0]       phaseLen,
  output logic [SIDES-1:0]                  gate,
  output logic [SIDES-1:0]                  full,
  output logic [SIDES-1:0][CODE_W-1:0]      code
);

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic              gateQ;
    logic              fullQ;
    logic [CODE_W-1:0] codeQ;

    assign phaseLen[s] = CNT_W'(nsToCycles(tonNs(tonSel[s]), CLK_MHZ));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gateQ <= 1'b0;
        fullQ <= 1'b0;
        codeQ <= '0;
      end else if (strobe[s].off) begin
        gateQ <= 1'b0;
        fullQ <= 1'b0;
        codeQ <= '0;
      end else if (strobe[s].launch) begin
        gateQ <= strobe[s].rise;
        fullQ <= 1'b0;
        codeQ <= strobe[s].rise ? srcSel[s] : snkSel[s];
      end else if (strobe[s].expire) begin
        fullQ <= 1'b1;
        codeQ <= '0;
      end
    end

    assign gate[s] = gateQ;
    assign full[s] = fullQ;
    assign code[s] = codeQ;
  end

endmodule

// File: rtl/gdrv_slew_timer.sv
module gdrv_slew_timer
  import gdrv_slew_pkg::*;
#(
  parameter int CLK_MHZ = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       drvEn,
  input  logic       pwmHi,
  input  logic       pwmLo,
  input  logic [2:0] tonHi,
  input  logic [2:0] tonLo,
  input  logic [2:0] srcHi,
  input  logic [2:0] snkHi,
  input  logic [2:0] srcLo,
  input  logic [2:0] snkLo,
  output logic       gateHi,
  output logic       gateLo,
  output logic       slewHi,
  output logic       slewLo,
  output logic       fullHi,
  output logic       fullLo,
  output logic [2:0] codeHi,
  output logic [2:0] codeLo
);

  localparam int MAX_CYC = nsToCycles(4700, CLK_MHZ);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_strobe_t [SIDES-1:0]         strobe;
  logic [SIDES-1:0][CNT_W-1:0]       phaseLen;
  logic [SIDES-1:0]                  slew;
  logic [SIDES-1:0]                  gate;
  logic [SIDES-1:0]                  full;
  logic [SIDES-1:0][CODE_W-1:0]      code;

  gdrv_slew_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .drvEn    (drvEn),
    .pwm      ({pwmLo, pwmHi}),
    .phaseLen (phaseLen),
    .strobe   (strobe),
    .slew     (slew)
  );

  gdrv_slew_dp #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tonSel   ({tonLo, tonHi}),
    .srcSel   ({srcLo, srcHi}),
    .snkSel   ({snkLo, snkHi}),
    .phaseLen (phaseLen),
    .gate     (gate),
    .full     (full),
    .code     (code)
  );

  assign gateHi = gate[SIDE_HI];
  assign gateLo = gate[SIDE_LO];
  assign slewHi = slew[SIDE_HI];
  assign slewLo = slew[SIDE_LO];
  assign fullHi = full[SIDE_HI];
  assign fullLo = full[SIDE_LO];
  assign codeHi = code[SIDE_HI];
  assign codeLo = code[SIDE_LO];

endmodule

// File: rtl/gdrv_slew_checker.sv
module gdrv_slew_checker (
  input logic       clk,
  input logic       rstN,
  input logic       drvEn,
  input logic       pwmHi,
  input logic       pwmLo,
  input logic [2:0] tonHi,
  input logic [2:0] tonLo,
  input logic [2:0] srcHi,
  input logic [2:0] snkHi,
  input logic [2:0] srcLo,
  input logic [2:0] snkLo,
  input logic       gateHi,
  input logic       gateLo,
  input logic       slewHi,
  input logic       slewLo,
  input logic       fullHi,
  input logic       fullLo,
  input logic [2:0] codeHi,
  input logic [2:0] codeLo
);

  a_r2_hi_edge_starts: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && (pwmHi != gateHi)) |=> (slewHi && (gateHi == $past(pwmHi))));
  a_r2_lo_edge_starts: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && (pwmLo != gateLo)) |=> (slewLo && (gateLo == $past(pwmLo))));

  a_r4_hi_code_dir: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && (pwmHi != gateHi)) |=> (codeHi == (gateHi ? $past(srcHi) : $past(snkHi))));
  a_r4_lo_code_dir: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && (pwmLo != gateLo)) |=> (codeLo == (gateLo ? $past(srcLo) : $past(snkLo))));

  a_r5_hi_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(slewHi && fullHi));
  a_r5_lo_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(slewLo && fullLo));
  a_r5_hi_code_idle: assert property (@(posedge clk) disable iff (!rstN)
    !slewHi |-> (codeHi == 3'd0));
  a_r5_lo_code_idle: assert property (@(posedge clk) disable iff (!rstN)
    !slewLo |-> (codeLo == 3'd0));
  a_r5_hi_full_after_phase: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullHi) |-> $past(slewHi));

  a_r7_off_clears: assert property (@(posedge clk) disable iff (!rstN)
    !drvEn |=> (!gateHi && !gateLo && !slewHi && !slewLo && !fullHi && !fullLo));

  a_r8_hi_code_held: assert property (@(posedge clk) disable iff (!rstN)
    (slewHi && $past(slewHi) && $stable(gateHi)) |-> $stable(codeHi));
  a_r8_lo_code_held: assert property (@(posedge clk) disable iff (!rstN)
    (slewLo && $past(slewLo) && $stable(gateLo)) |-> $stable(codeLo));

endmodule

bind gdrv_slew_timer gdrv_slew_checker chk_i (.*);

// File: tb/gdrv_slew_timer_tb_top.sv
module gdrv_slew_timer_tb_top;

  localparam int CLK_MHZ = 125;

  typedef struct {
    int         cyc;
    bit         side;     // 0 high side, 1 low side
    logic       gate;
    logic       slew;
    logic       full;
    logic [2:0] code;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN, drvEn, pwmHi, pwmLo;
  logic [2:0] tonHi, tonLo, srcHi, snkHi, srcLo, snkLo;
  logic gateHi, gateLo, slewHi, slewLo, fullHi, fullLo;
  logic [2:0] codeHi, codeLo;

  int   cyc = 0;
  int   nChecks = 0;
  int   nFail = 0;
  bit   reported = 0;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gdrv_slew_timer #(.CLK_MHZ(CLK_MHZ)) dut_i (
    .clk(clk), .rstN(rstN), .drvEn(drvEn), .pwmHi(pwmHi), .pwmLo(pwmLo),
    .tonHi(tonHi), .tonLo(tonLo), .srcHi(srcHi), .snkHi(snkHi),
    .srcLo(srcLo), .snkLo(snkLo), .gateHi(gateHi), .gateLo(gateLo),
    .slewHi(slewHi), .slewLo(slewLo), .fullHi(fullHi), .fullLo(fullLo),
    .codeHi(codeHi), .codeLo(codeLo)
  );

  // phase length from the time table, rounded up
  function automatic int phaseCycles(input int sel);
    int ns[8] = '{4700, 2500, 1800, 1300, 1100, 900, 750, 550};
    return (ns[sel] * CLK_MHZ + 999) / 1000;
  endfunction

  task automatic expectAt(input int c, input bit side, input logic g, input logic s,
                          input logic f, input logic [2:0] cd, input string tag);
    exp_t e;
    e.cyc = c; e.side = side; e.gate = g; e.slew = s; e.full = f; e.code = cd; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic stepTo(input int c);
    while (cyc < c) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc <= cyc) begin
        logic g, s, f;
        logic [2:0] cd;
        g  = sb[i].side ? gateLo : gateHi;
        s  = sb[i].side ? slewLo : slewHi;
        f  = sb[i].side ? fullLo : fullHi;
        cd = sb[i].side ? codeLo : codeHi;
        nChecks++;
        if (sb[i].cyc != cyc || g !== sb[i].gate || s !== sb[i].slew ||
            f !== sb[i].full || cd !== sb[i].code) begin
          nFail++;
          $display("FAIL %s side%0d cyc %0d: got g%b s%b f%b c%0d, expected g%b s%b f%b c%0d",
                   sb[i].tag, sb[i].side, cyc, g, s, f, cd,
                   sb[i].gate, sb[i].slew, sb[i].full, sb[i].code);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    #(8 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired at cyc %0d, expected end before 200000", cyc);
    report();
  end

  initial begin
    int k, n;
    rstN = 0; drvEn = 1; pwmHi = 0; pwmLo = 0;
    tonHi = 0; tonLo = 0; srcHi = 0; snkHi = 0; srcLo = 0; snkLo = 0;
    // R1: reset state on both sides
    expectAt(2, 0, 0, 0, 0, 0, "R1");
    expectAt(2, 1, 0, 0, 0, 0, "R1");
    expectAt(6, 0, 0, 0, 0, 0, "R1");
    expectAt(6, 1, 0, 0, 0, 0, "R1");
    stepTo(3);
    rstN = 1;

    // R2 R3 R4: high side rises with the longest time code
    k = 10; n = phaseCycles(0);
    expectAt(k + 1, 0, 1, 1, 0, 5, "R2");
    expectAt(k + n, 0, 1, 1, 0, 5, "R3");
    expectAt(k + n + 1, 0, 1, 0, 1, 0, "R3");
    expectAt(650, 0, 1, 0, 1, 0, "R5");
    stepTo(k);
    srcHi = 5; tonHi = 0; pwmHi = 1;

    // R4 sink code, R3 shortest time code
    k = 700; n = phaseCycles(7);
    expectAt(k + 1, 0, 0, 1, 0, 3, "R4");
    expectAt(k + n, 0, 0, 1, 0, 3, "R3");
    expectAt(k + n + 1, 0, 0, 0, 1, 0, "R5");
    stepTo(k);
    tonHi = 7; snkHi = 3; pwmHi = 0;

    // R9: low side phase, high side untouched
    k = 800; n = phaseCycles(3);
    expectAt(k + 1, 1, 1, 1, 0, 7, "R9");
    expectAt(850, 0, 0, 0, 1, 0, "R9");
    expectAt(k + n, 1, 1, 1, 0, 7, "R3");
    expectAt(k + n + 1, 1, 1, 0, 1, 0, "R3");
    stepTo(k);
    tonLo = 3; srcLo = 7; tonHi = 2; pwmLo = 1;

    // R6: restart during an active phase
    k = 1000; n = phaseCycles(7);
    expectAt(k + 1, 1, 0, 1, 0, 2, "R6");
    expectAt(k + 11, 1, 1, 1, 0, 6, "R6");
    expectAt(k + n + 1, 1, 1, 1, 0, 6, "R6");
    expectAt(k + 10 + n, 1, 1, 1, 0, 6, "R6");
    expectAt(k + 11 + n, 1, 1, 0, 1, 0, "R6");
    stepTo(k);
    tonLo = 7; snkLo = 2; pwmLo = 0;
    stepTo(k + 10);
    srcLo = 6; pwmLo = 1;

    // R8: configuration changes during a phase are ignored
    k = 1200; n = phaseCycles(5);
    expectAt(1250, 0, 1, 1, 0, 4, "R8");
    expectAt(k + n, 0, 1, 1, 0, 4, "R8");
    expectAt(k + n + 1, 0, 1, 0, 1, 0, "R8");
    stepTo(k);
    tonHi = 5; srcHi = 4; pwmHi = 1;
    stepTo(k + 5);
    srcHi = 1; tonHi = 0; snkHi = 6;

    // R7: enable low clears outputs, blocks phases; re-enable starts rising phase
    k = 1400;
    expectAt(1401, 1, 0, 1, 0, 1, "R7");
    expectAt(1421, 1, 0, 0, 0, 0, "R7");
    expectAt(1421, 0, 0, 0, 0, 0, "R7");
    expectAt(1440, 0, 0, 0, 0, 0, "R7");
    expectAt(1440, 1, 0, 0, 0, 0, "R7");
    n = phaseCycles(7);
    expectAt(1451, 0, 1, 1, 0, 2, "R7");
    expectAt(1460, 1, 0, 0, 0, 0, "R7");
    expectAt(1450 + n, 0, 1, 1, 0, 2, "R7");
    expectAt(1451 + n, 0, 1, 0, 1, 0, "R7");
    stepTo(k);
    tonLo = 0; snkLo = 1; pwmLo = 0;
    stepTo(1420);
    drvEn = 0;
    stepTo(1430);
    pwmHi = 0;
    stepTo(1435);
    pwmHi = 1;
    stepTo(1445);
    tonHi = 7; srcHi = 2;
    stepTo(1450);
    drvEn = 1;

    stepTo(1600);
    if (sb.size() != 0) begin
      nChecks++;
      nFail++;
      $display("FAIL scoreboard: %0d items never checked, expected 0", sb.size());
    end
    report();
  end

endmodule